// File: doc/BRIEF.md
# Registered Read-Only Memory with Selectable Output Enable

This block models a 2048-word by 8-bit read-only store whose read path ends in an edge-triggered output register. On every rising clock edge the word addressed by `addr` is captured, and the captured word stays on the output until the next edge. The address can therefore move to the next location straight after an edge while the previous word stays steady. This is the usual arrangement for pipelined microcode and lookup tables.

One active-low enable pin controls whether the outputs are driven. A stored configuration byte decides how that pin acts. It either gates the outputs directly or passes through a flop, so that the outputs turn on and off only at clock edges. A separate active-low, level-sensitive initialize input loads a stored initialize word into the output register at once, whatever the clock is doing. Tri-state is modelled by an output-valid flag. The data bus reads zero whenever the outputs are off. A preload write port fills the array, the initialize word and the configuration byte. These are non-volatile and survive the power-on reset.

Top module: `regrom`

## Requirements
- R1: On each rising clock edge, with `initN` high, the output register captures the array word at `addr`. While enabled, that word appears on `dataOut` right after the edge.
- R2: A change of `addr` between clock edges does not change `dataOut`.
- R3: While `wrEn` is high, a rising edge stores `wrData` into the location given by `wrAddr`:
  - values 0 to 2047 select an array word;
  - 0x800 selects the initialize word;
  - 0x801 selects the configuration byte;
  - any other `wrAddr` value changes nothing.
- R4: A configuration byte of 0x01 selects synchronous enable. Every other value selects asynchronous enable. The byte starts at 0x00, so asynchronous enable is the default.
- R5: In asynchronous mode, `outValid` equals the inverse of `enN` at all times, with no clock involved.
- R6: In synchronous mode, `outValid` changes only at a rising edge. After each edge it shows the inverse of `enN` as sampled at that edge.
- R7: Power-on reset (`rstN` low) clears the output register. It also puts the synchronous enable flop in its disabled state, so in synchronous mode the outputs stay off after reset until an edge samples `enN` low.
- R8: While `initN` is low, the output register holds the initialize word. The load happens at once, without a clock edge, and it takes priority over any clock edge.
- R9: In asynchronous mode, initialize data appears on `dataOut` only once `enN` is low.
- R10: When `initN` goes high, the register keeps the initialize word until the next rising edge. From that edge on, normal registered reads resume.
- R11: Whenever `outValid` is low, `dataOut` is zero.
- R12: An initialize word of 0x00 makes initialize clear the register, and a word of 0xFF makes it a preset to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| addr | input | 11 | Read address |
| enN | input | 1 | Active-low output enable |
| initN | input | 1 | Active-low level-sensitive initialize |
| wrEn | input | 1 | Preload write strobe |
| wrAddr | input | 12 | Preload location (array, 0x800 init word, 0x801 config) |
| wrData | input | 8 | Preload data |
| dataOut | output | 8 | Registered read data, zero when outputs are off |
| outValid | output | 1 | High when the outputs are driven |

## Verification
Suppose the synchronous enable flop or the mode decode holds a wrong value. `outValid` then departs from `enN` either immediately in asynchronous mode or one edge late in synchronous mode, so the error shows within one clock. If the output register captured the wrong source, for example a read where an initialize load was due, or a read between edges, `dataOut` is wrong on the very next sample. A bad preload decode shows only later, when that location is read or initialize is pulsed, so each preload target is read back through the ports.

// File: rtl/regrom_pkg.sv
package regrom_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic wrArray;
    logic wrInit;
    logic wrCfg;
    logic initLoad;
  } romStb_t;
endpackage

// File: rtl/regrom_ctrl.sv
module regrom_ctrl
  import regrom_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enN,
  input  logic          initN,
  input  logic          wrEn,
  input  logic [AW:0]   wrAddr,
  input  logic          syncMode,
  output romStb_t       stb,
  output logic          outValid
);
  localparam logic [AW:0] INIT_SLOT = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] CFG_SLOT  = INIT_SLOT + 1'b1;

  logic syncOff;

  always_comb begin
    stb.wrArray  = wrEn && !wrAddr[AW];
    stb.wrInit   = wrEn && (wrAddr == INIT_SLOT);
    stb.wrCfg    = wrEn && (wrAddr == CFG_SLOT);
    stb.initLoad = !initN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncOff <= 1'b1;
    else       syncOff <= enN;
  end

  assign outValid = syncMode ? !syncOff : !enN;
endmodule

// File: rtl/regrom_store.sv
module regrom_store
  import regrom_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  romStb_t       stb,
  input  logic [AW-1:0] addr,
  input  logic [AW:0]   wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] regData,
  output logic [DW-1:0] initWord,
  output logic          syncMode
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] SYNC_CODE = DW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cfgByte = '0;
  logic [DW-1:0] initReg = '0;
  logic          initLoad;

  assign initLoad = stb.initLoad;

  always_ff @(posedge clk) begin
    if (stb.wrArray) mem[wrAddr[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (stb.wrInit) initReg <= wrData;
    if (stb.wrCfg)  cfgByte <= wrData;
  end

  always_ff @(posedge clk or negedge rstN or posedge initLoad) begin
    if (!rstN)         regData <= '0;
    else if (initLoad) regData <= initReg;
    else               regData <= mem[addr];
  end

  assign initWord = initReg;
  assign syncMode = (cfgByte == SYNC_CODE);
endmodule

// File: rtl/regrom.sv
module regrom
  import regrom_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          enN,
  input  logic          initN,
  input  logic          wrEn,
  input  logic [AW:0]   wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] dataOut,
  output logic          outValid
);
  romStb_t       stb;
  logic [DW-1:0] regData;
  logic [DW-1:0] initWord;
  logic          syncMode;

  regrom_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enN(enN), .initN(initN), .wrEn(wrEn),
    .wrAddr(wrAddr), .syncMode(syncMode), .stb(stb), .outValid(outValid)
  );

  regrom_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrAddr(wrAddr),
    .wrData(wrData), .regData(regData), .initWord(initWord),
    .syncMode(syncMode)
  );

  assign dataOut = outValid ? regData : '0;
endmodule

// File: rtl/regrom_checker.sv
module regrom_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          enN,
  input logic          initN,
  input logic          outValid,
  input logic [DW-1:0] dataOut,
  input logic [DW-1:0] initWord,
  input logic          syncMode
);
  logic pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R11: outputs off means a zero bus
  a_r11_off_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (dataOut == '0));

  // R5: asynchronous mode with enable high keeps outputs off
  a_r5_async_off: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && enN) |-> !outValid);

  // R6: synchronous mode follows enable sampled one edge earlier
  a_r6_sync_follow: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && syncMode && $past(syncMode)) |-> (outValid == !$past(enN)));

  // R8: while initialize is low, enabled outputs show the initialize word
  a_r8_init_word: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !initN && outValid && $stable(initWord)) |-> (dataOut == initWord));
endmodule

bind regrom regrom_checker #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .enN(enN), .initN(initN), .outValid(outValid),
  .dataOut(dataOut), .initWord(initWord), .syncMode(syncMode)
);

// File: tb/regrom_bench.sv
`timescale 1ns/1ps
module regrom_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] addr = '0;
  logic        enN = 1'b1;
  logic        initN = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  dataOut;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  regrom u_regrom (
    .clk(clk), .rstN(rstN), .addr(addr), .enN(enN), .initN(initN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dataOut(dataOut), .outValid(outValid)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37) + (i >> 8) + 5);
  endfunction

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
               tag, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    #1 check("R7 reset off", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    #1 check("R5 R7 async on in reset, cleared reg", {outValid, dataOut}, {1'b1, 8'h00});
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_preload();
    for (int i = 0; i < 2048; i++) wr(12'(i), pat(i));
    wr(12'h800, 8'hA5);
    wr(12'h801, 8'h00);
  endtask

  task automatic t_reads();
    int list [5] = '{0, 1, 700, 1500, 2047};
    foreach (list[k]) begin
      addr = 11'(list[k]);
      step();
      check("R1 registered read", {outValid, dataOut}, {1'b1, pat(list[k])});
    end
    addr = 11'd9;
    step();
    addr = 11'd10;
    #3 check("R2 address change between edges", {outValid, dataOut}, {1'b1, pat(9)});
    step();
    check("R1 read after move", {outValid, dataOut}, {1'b1, pat(10)});
  endtask

  task automatic t_async_enable();
    enN = 1'b1;
    #1 check("R5 async off at once", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    #1 check("R5 async on at once", {outValid, dataOut}, {1'b1, pat(10)});
  endtask

  task automatic t_init();
    addr = 11'd20;
    initN = 1'b0;
    #1 check("R8 init immediate", {outValid, dataOut}, {1'b1, 8'hA5});
    step();
    check("R8 init beats edge", {outValid, dataOut}, {1'b1, 8'hA5});
    initN = 1'b1;
    #1 check("R10 hold after release", {outValid, dataOut}, {1'b1, 8'hA5});
    step();
    check("R10 read resumes", {outValid, dataOut}, {1'b1, pat(20)});
    enN = 1'b1; initN = 1'b0;
    #1 check("R9 init hidden while disabled", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    #1 check("R9 init shown once enabled", {outValid, dataOut}, {1'b1, 8'hA5});
    initN = 1'b1;
    step();
  endtask

  task automatic t_clear_preset();
    wr(12'h800, 8'h00);
    initN = 1'b0;
    #1 check("R12 init clear", {outValid, dataOut}, {1'b1, 8'h00});
    initN = 1'b1;
    wr(12'h800, 8'hFF);
    initN = 1'b0;
    #1 check("R12 init preset", {outValid, dataOut}, {1'b1, 8'hFF});
    initN = 1'b1;
    step();
  endtask

  task automatic t_ignored_write();
    wr(12'h802, 8'h3C);
    addr = 11'd2;
    step();
    check("R3 stray write leaves array", {outValid, dataOut}, {1'b1, pat(2)});
    initN = 1'b0;
    #1 check("R3 stray write leaves init word", {outValid, dataOut}, {1'b1, 8'hFF});
    initN = 1'b1;
    step();
    enN = 1'b1;
    #1 check("R3 stray write leaves async mode", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    step();
  endtask

  task automatic t_sync();
    addr = 11'd33;
    wr(12'h801, 8'h01);
    check("R4 sync mode on, enabled", {outValid, dataOut}, {1'b1, pat(33)});
    enN = 1'b1;
    #1 check("R6 no change before edge", {outValid, dataOut}, {1'b1, pat(33)});
    step();
    check("R6 R11 off at edge", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    #1 check("R6 still off before edge", {outValid, dataOut}, {1'b0, 8'h00});
    step();
    check("R6 on at edge", {outValid, dataOut}, {1'b1, pat(33)});
    rstN = 1'b0;
    #1 check("R7 sync reset off", {outValid, dataOut}, {1'b0, 8'h00});
    @(negedge clk); rstN = 1'b1;
    #1 check("R7 sync stays off after reset", {outValid, dataOut}, {1'b0, 8'h00});
    step();
    check("R7 first edge enables", {outValid, dataOut}, {1'b1, pat(33)});
  endtask

  task automatic t_other_code();
    wr(12'h801, 8'h02);
    enN = 1'b1;
    #1 check("R4 code 0x02 is async", {outValid, dataOut}, {1'b0, 8'h00});
    enN = 1'b0;
    #1 check("R4 code 0x02 async on", {outValid, dataOut}, {1'b1, pat(33)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    step();
    t_preload();
    t_reads();
    t_async_enable();
    t_init();
    t_clear_preset();
    t_ignored_write();
    t_sync();
    t_other_code();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule